// File: doc/BRIEF.md
# Orientation-Addressed Bit-Matrix Memory

This block stores an N×N grid of single-bit cells (N = 16 by default, so 256 cells) and moves one N-bit word per access. A word is not limited to a horizontal slice of the grid. A 2-bit orientation tag chooses whether the word is a row, a column, the main diagonal or the anti-diagonal. It is aimed at vector engines that transpose or stride through small matrices, where a plain linear memory would need N accesses to gather a single column.

An access begins with a load strobe. On that strobe, a word index and an orientation tag are captured into address registers. From the following cycle on, the read port shows the selected word combinationally. While the read/write control is low, each clock edge writes the data input into exactly the N cells of the selected word. A row decoder and a column decoder pick the cells in two dimensions. The stored contents are never reset. Reset clears only the address registers.

Top module: `orient_bitmatrix_mem`

## Requirements
- R1: With tag 2'b00 (row) and index i, bit k of the word is cell (row i, column k) for both read and write.
- R2: With tag 2'b01 (column) and index i, bit k of the word is cell (row k, column i) for both read and write.
- R3: With tag 2'b10 (main diagonal), bit k of the word is cell (k, k), and the index value has no effect.
- R4: With tag 2'b11 (anti-diagonal), bit k of the word is cell (k, N-1-k), and the index value has no effect.
- R5: When rd_nwr is 0 at a rising clock edge, the N cells of the selected word take the value of wdata. No other cell changes, and the written word reads back on the next cycle.
- R6: When rd_nwr is 1, no cell changes. rdata follows the selected cells with no clock delay and stays steady while the address registers and the contents are unchanged.
- R7: Index and tag are captured only at an edge where addr_ld is 1, and they hold otherwise. A synchronous reset (rst_n low) sets them to index 0 with the row tag.
- R8: No cell is written at an edge where rst_n is low, whatever the value of rd_nwr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and address captures occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the address registers |
| addr_ld | input | 1 | Strobe that captures addr_idx and addr_tag |
| addr_idx | input | IDXW (4) | Word index: row or column number |
| addr_tag | input | 2 | Orientation: 00 row, 01 column, 10 main diagonal, 11 anti-diagonal |
| rd_nwr | input | 1 | 1 = read only, 0 = write the selected word at the edge |
| wdata | input | N (16) | Word to be written |
| rdata | output | N (16) | Selected word, combinational from the registered address |

## Verification
The bench drives inputs just after a rising edge. A load strobe therefore takes effect at the next edge, and the new word is due on rdata within that same cycle. A write issued after a load lands one edge later and is visible from the cycle that follows. The driver pushes each expected word, taken from a software copy of the matrix, into a queue once the edge that makes it due has passed. The monitor compares at the following falling edge, so every comparison falls half a period after the last register on the path has updated.

// File: rtl/bmx_pkg.sv
// Package: shared orientation type for the bit-matrix memory.
// Assumes the tag encoding below is fixed by the block's requirements.
package bmx_pkg;
    typedef enum logic [1:0] {
        ORI_ROW  = 2'b00,
        ORI_COL  = 2'b01,
        ORI_DIAG = 2'b10,
        ORI_ANTI = 2'b11
    } orient_e;
endpackage

// File: rtl/bmx_addr_reg.sv
// Module: address registers holding the word index and orientation tag.
// Assumes a synchronous active-low reset; captures only on the load strobe.
module bmx_addr_reg
    import bmx_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [IDXW-1:0] idx_in,
    input  logic [1:0]      tag_in,
    output logic [IDXW-1:0] idx_q,
    output orient_e         tag_q
);
    // Capture index and tag on the strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tag_q <= ORI_ROW;
        end else if (ld) begin
            idx_q <= idx_in;
            tag_q <= orient_e'(tag_in);
        end
    end

    // R7: a strobe captures the presented index and tag.
    a_r7_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (idx_q == $past(idx_in)) && (tag_q == orient_e'($past(tag_in))));

    // R7: without a strobe the address holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(idx_q) && $stable(tag_q));
endmodule

// File: rtl/bmx_sel_decode.sv
// Module: two-dimensional cell selection for one word access.
// Produces a per-cell select map for writes and per-bit row/column
// coordinates for the read mux. Assumes N is a power of two.
module bmx_sel_decode
    import bmx_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic [IDXW-1:0] idx,
    input  orient_e         tag,
    output logic [N*N-1:0]  sel,
    output logic [IDXW-1:0] rd_row [N],
    output logic [IDXW-1:0] rd_col [N]
);
    logic [N-1:0] idx_oh;

    // Index to one-hot line decode shared by the row and column selects.
    always_comb begin
        idx_oh = '0;
        idx_oh[idx] = 1'b1;
    end

    // Cell select map: each cell asks whether it lies on the chosen word.
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam bit ON_DIAG = (r == c);
            localparam bit ON_ANTI = (r + c == N - 1);
            assign sel[r*N+c] = ((tag == ORI_ROW)  && idx_oh[r]) ||
                                ((tag == ORI_COL)  && idx_oh[c]) ||
                                ((tag == ORI_DIAG) && ON_DIAG)   ||
                                ((tag == ORI_ANTI) && ON_ANTI);
        end
    end

    // Coordinates of the cell feeding each read-data bit.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            unique case (tag)
                ORI_ROW:  begin rd_row[k] = idx;           rd_col[k] = IDXW'(k);         end
                ORI_COL:  begin rd_row[k] = IDXW'(k);      rd_col[k] = idx;              end
                ORI_DIAG: begin rd_row[k] = IDXW'(k);      rd_col[k] = IDXW'(k);         end
                default:  begin rd_row[k] = IDXW'(k);      rd_col[k] = IDXW'(N - 1 - k); end
            endcase
        end
    end
endmodule

// File: rtl/bmx_cell_array.sv
// Module: N x N storage cells with per-cell write enable and word read mux.
// Contents are not reset. Assumes the select map marks exactly one word.
module bmx_cell_array
    import bmx_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  orient_e         tag,
    input  logic [N*N-1:0]  sel,
    input  logic [IDXW-1:0] rd_row [N],
    input  logic [IDXW-1:0] rd_col [N],
    input  logic [N-1:0]    wdata,
    output logic [N-1:0]    rdata
);
    logic [N-1:0]   cells [N];
    logic [N*N-1:0] din;

    // Route the write-data bit that belongs to each cell.
    for (genvar r = 0; r < N; r++) begin : g_dr
        for (genvar c = 0; c < N; c++) begin : g_dc
            assign din[r*N+c] = (tag == ORI_ROW) ? wdata[c] : wdata[r];
        end
    end

    // Load the selected cells on a write edge; all others keep their value.
    always_ff @(posedge clk) begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (wr_en && sel[r*N+c]) cells[r][c] <= din[r*N+c];
            end
        end
    end

    // Combinational word read through the per-bit coordinates.
    always_comb begin
        for (int k = 0; k < N; k++) rdata[k] = cells[rd_row[k]][rd_col[k]];
    end

    // R5: every orientation marks exactly N cells.
    a_r5_word_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == N);
endmodule

// File: rtl/orient_bitmatrix_mem.sv
// Module: top of the orientation-addressed bit-matrix memory.
// Registers index and tag on a strobe, decodes the word in two dimensions,
// writes synchronously when rd_nwr is low and reads combinationally.
module orient_bitmatrix_mem
    import bmx_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_ld,
    input  logic [IDXW-1:0] addr_idx,
    input  logic [1:0]      addr_tag,
    input  logic            rd_nwr,
    input  logic [N-1:0]    wdata,
    output logic [N-1:0]    rdata
);
    logic [IDXW-1:0] idx_q;
    orient_e         tag_q;
    logic [N*N-1:0]  sel;
    logic [IDXW-1:0] rd_row [N];
    logic [IDXW-1:0] rd_col [N];
    logic            wr_en;

    // Writes are blocked during reset and whenever read is requested.
    assign wr_en = rst_n && !rd_nwr;

    bmx_addr_reg #(.IDXW(IDXW)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld(addr_ld),
        .idx_in(addr_idx), .tag_in(addr_tag),
        .idx_q(idx_q), .tag_q(tag_q)
    );

    bmx_sel_decode #(.N(N), .IDXW(IDXW)) u_dec (
        .idx(idx_q), .tag(tag_q), .sel(sel),
        .rd_row(rd_row), .rd_col(rd_col)
    );

    bmx_cell_array #(.N(N), .IDXW(IDXW)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tag(tag_q), .sel(sel),
        .rd_row(rd_row), .rd_col(rd_col), .wdata(wdata), .rdata(rdata)
    );

    // R5: a written word reads back on the next cycle at the same address.
    a_r5_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_nwr) && !$past(addr_ld)) |-> rdata == $past(wdata));

    // R6: a read cycle with no address load leaves the output unchanged.
    a_r6_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_nwr) && !$past(addr_ld)) |-> $stable(rdata));
endmodule

// File: tb/sim_orient_bitmatrix_mem.sv
module sim_orient_bitmatrix_mem;
    localparam int N = 16;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            addr_ld = 1'b0;
    logic [IDXW-1:0] addr_idx = '0;
    logic [1:0]      addr_tag = '0;
    logic            rd_nwr = 1'b1;
    logic [N-1:0]    wdata = '0;
    logic [N-1:0]    rdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [N-1:0] model [N];
    int cur_idx = 0;
    int cur_tag = 0;
    logic [N-1:0] exp_q [$];
    string        req_q [$];

    always #5 clk = ~clk;

    orient_bitmatrix_mem #(.N(N), .IDXW(IDXW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_idx(addr_idx),
        .addr_tag(addr_tag), .rd_nwr(rd_nwr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [N-1:0] model_word(input int idx, input int tag);
        logic [N-1:0] w;
        for (int k = 0; k < N; k++) begin
            case (tag)
                0: w[k] = model[idx][k];
                1: w[k] = model[k][idx];
                2: w[k] = model[k][k];
                default: w[k] = model[k][N-1-k];
            endcase
        end
        return w;
    endfunction

    task automatic model_store(input int idx, input int tag, input logic [N-1:0] d);
        for (int k = 0; k < N; k++) begin
            case (tag)
                0: model[idx][k] = d[k];
                1: model[k][idx] = d[k];
                2: model[k][k] = d[k];
                default: model[k][N-1-k] = d[k];
            endcase
        end
    endtask

    // Monitor: pops one expected word per falling edge and compares.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", r, rdata, e);
            end
        end
    end

    task automatic load(input int idx, input int tag);
        @(posedge clk); #1;
        addr_ld = 1'b1; addr_idx = IDXW'(idx); addr_tag = 2'(tag); rd_nwr = 1'b1;
        @(posedge clk); #1;
        addr_ld = 1'b0;
        cur_idx = idx; cur_tag = tag;
    endtask

    task automatic expect_now(input string req);
        exp_q.push_back(model_word(cur_idx, cur_tag));
        req_q.push_back(req);
        @(negedge clk); #1;
    endtask

    task automatic read(input int idx, input int tag, input string req);
        load(idx, tag);
        expect_now(req);
    endtask

    task automatic write(input int idx, input int tag, input logic [N-1:0] d);
        load(idx, tag);
        rd_nwr = 1'b0; wdata = d;
        @(posedge clk); #1;
        rd_nwr = 1'b1;
        model_store(idx, tag, d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        // R7: reset address is row 0; write without a load lands there.
        rst_n = 1'b1; rd_nwr = 1'b0; wdata = 16'hC0DE;
        @(posedge clk); #1;
        rd_nwr = 1'b1;
        model_store(0, 0, 16'hC0DE);
        cur_idx = 0; cur_tag = 0;
        expect_now("R7 reset address row 0");

        // R8: write request during reset must not reach the cells.
        @(posedge clk); #1;
        rst_n = 1'b0; rd_nwr = 1'b0; wdata = 16'hFFFF;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1; rd_nwr = 1'b1;
        cur_idx = 0; cur_tag = 0;
        expect_now("R8 no write in reset");

        // R1: fill every row with a distinct pattern, spot-check rows.
        for (int r = 0; r < N; r++) write(r, 0, 16'(r * 16'h2F1B) ^ 16'h9C35);
        for (int r = 0; r < N; r += 5) read(r, 0, "R1 row read");

        // R2: every column gathered from the row-written data.
        for (int c = 0; c < N; c++) read(c, 1, "R2 column read");

        // R3/R4: diagonals, two different indices each (index ignored).
        read(0, 2, "R3 main diagonal idx0");
        read(9, 2, "R3 main diagonal idx9");
        read(3, 3, "R4 anti-diagonal idx3");
        read(15, 3, "R4 anti-diagonal idx15");

        // R5: write one column, only that column changes in every row.
        write(5, 1, 16'h5A0F);
        for (int r = 0; r < N; r++) read(r, 0, "R5 rows after column write");

        // R3: diagonal write with an index value that must be ignored.
        write(7, 2, 16'hFFFF);
        read(2, 2, "R3 diagonal readback");
        for (int r = 0; r < 4; r++) read(r, 0, "R3 rows after diagonal write");

        // R4: anti-diagonal write, then check a crossing column.
        write(11, 3, 16'h0000);
        read(0, 3, "R4 anti-diagonal readback");
        read(15, 1, "R4 column after anti-diagonal write");
        read(2, 1, "R2 column after both diagonal writes");

        // R6: held read with no load keeps giving the same word.
        read(3, 0, "R6 read");
        repeat (3) @(posedge clk);
        #1;
        expect_now("R6 held read");
        expect_now("R6 held read again");

        // R7: changing address pins without the strobe has no effect.
        addr_idx = 4'd12; addr_tag = 2'd1;
        repeat (2) @(posedge clk);
        #1;
        expect_now("R7 address hold without strobe");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule